// File: doc/BRIEF.md
# Channel-Interleaved 2x Nearest-Neighbour Upsampler

This block enlarges a feature map by a factor of two in both dimensions by repeating each pixel once horizontally and each widened row once vertically. Samples arrive in raster order on a single bus, with all channel values of one pixel sent back to back before the next pixel starts. Every accepted sample is forwarded to the output at once. A small per-pixel buffer keeps that pixel's channels so they can be emitted a second time. A row-sized buffer records everything emitted for the current row so the whole widened row can be played out again.

The upstream source is throttled with a ready signal while a pixel or a row is being replayed. The output has no back-pressure. Each emitted sample is qualified by a valid flag. For one input row of `WIDTH` pixels, the output carries `4*WIDTH*CHANNELS` samples. They are ordered by output row, then output column, then channel.

Top module: `upx2_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A sample accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on `out_data` with `out_valid` = 1 after that same edge, which is a latency of one cycle.
- R3: Once channel `CHANNELS-1` of a pixel is accepted, the next `CHANNELS` output cycles repeat that pixel's channels back to back, in order 0 to `CHANNELS-1`.
- R4: After the last channel of a pixel that does not end a row, `in_ready` stays 0 for exactly `CHANNELS+1` cycles. These are the column replay cycles plus one pixel-advance cycle.
- R5: After the last channel of the pixel at column `WIDTH-1`, the whole widened row of `2*WIDTH*CHANNELS` samples is emitted a second time on consecutive cycles. `in_ready` stays 0 for `CHANNELS+1+2*WIDTH*CHANNELS` cycles in total.
- R6: For each input row the output carries exactly `4*WIDTH*CHANNELS` samples. Output sample (output row 2r+k, output column j, channel c) equals input (row r, column j/2, channel c), for k in {0,1}.
- R7: A sample presented with `in_valid` = 1 while `in_ready` = 0 is held and consumed exactly once when `in_ready` returns. Within a pixel, `in_ready` stays 1 between channels.
- R8: In a cycle with no accepted input and no replay in progress, no output is produced.
- R9: Neither buffer is ever written when full or read when empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Input channel sample |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can take a sample this cycle |
| out_data | output | DATA_W | Output channel sample |
| out_valid | output | 1 | Output sample is valid this cycle |

## Verification
The bench targets the row-ending pixel. A design that miscounts pixels would replay the row too early or too late, and the stall-length and scoreboard checks would report it. The channel count is not a power of two, so a buffer pointer that wraps wrongly would replay stale or shifted channels. Input gaps in the middle of a pixel are inserted to expose a design that emits a sample on an idle cycle. The input is held valid through every stall to catch a design that consumes or duplicates a sample while it is not ready.

// File: rtl/upx_pkg.sv
package upx_pkg;

  typedef enum logic [1:0] {
    PH_PASS   = 2'd0,
    PH_COLREP = 2'd1,
    PH_NEXT   = 2'd2,
    PH_ROWREP = 2'd3
  } phase_t;

  // width of an index over n items, never below one bit
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // circular pointer advance for any depth
  function automatic int wrap_inc(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // size of the row buffer for a given row width and channel count
  function automatic int row_store(input int width, input int chans);
    return 2 * width * chans;
  endfunction

endpackage

// File: rtl/upx_fifo.sv
module upx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic              single
);
  localparam int AW = upx_pkg::idx_bits(DEPTH);
  localparam int CW = upx_pkg::idx_bits(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  assign dout   = mem[rd_ptr];
  assign empty  = (fill == '0);
  assign full   = (fill == CW'(DEPTH));
  assign single = (fill == CW'(1));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= AW'(upx_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(upx_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/upx_ctrl.sv
module upx_ctrl
  import upx_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int WIDTH    = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   row_empty,
  input  logic   row_single,
  output logic   in_ready,
  output logic   last_ch,
  output logic   sf_push,
  output logic   sf_pop,
  output logic   lf_push,
  output logic   lf_pop,
  output phase_t phase
);
  localparam int CHB = idx_bits(CHANNELS);
  localparam int PXB = idx_bits(WIDTH);

  phase_t nxt;
  logic [CHB-1:0] ch_q;
  logic [PXB-1:0] px_q;
  logic acc, ch_end, px_end;

  assign ch_end   = (ch_q == CHB'(CHANNELS - 1));
  assign px_end   = (px_q == PXB'(WIDTH - 1));
  assign in_ready = (phase == PH_PASS);
  assign acc      = in_valid && in_ready;
  assign last_ch  = ch_end;
  assign sf_push  = acc;
  assign sf_pop   = (phase == PH_COLREP);
  assign lf_push  = acc || sf_pop;
  assign lf_pop   = (phase == PH_ROWREP) && !row_empty;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_PASS:   if (acc && ch_end) nxt = PH_COLREP;
      PH_COLREP: if (ch_end) nxt = PH_NEXT;
      PH_NEXT:   nxt = px_end ? PH_ROWREP : PH_PASS;
      PH_ROWREP: if (lf_pop && row_single) nxt = PH_PASS;
      default:   nxt = PH_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PASS;
      ch_q  <= '0;
      px_q  <= '0;
    end else begin
      phase <= nxt;
      if (acc || sf_pop) ch_q <= ch_end ? '0 : ch_q + CHB'(1);
      if (phase == PH_NEXT) px_q <= px_end ? '0 : px_q + PXB'(1);
    end
  end
endmodule

// File: rtl/upx2_top.sv
module upx2_top
  import upx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHANNELS = 3,
  parameter int WIDTH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  localparam int ROW_DEPTH = row_store(WIDTH, CHANNELS);

  phase_t phase;
  logic last_ch, sf_push, sf_pop, lf_push, lf_pop;
  logic sf_empty, sf_full, sf_single, lf_empty, lf_full, lf_single;
  logic [DATA_W-1:0] sf_dout, lf_dout, lf_din, out_src;
  logic emit;

  upx_ctrl #(.CHANNELS(CHANNELS), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .row_empty(lf_empty), .row_single(lf_single),
    .in_ready(in_ready), .last_ch(last_ch),
    .sf_push(sf_push), .sf_pop(sf_pop), .lf_push(lf_push), .lf_pop(lf_pop),
    .phase(phase)
  );

  upx_fifo #(.DATA_W(DATA_W), .DEPTH(CHANNELS)) u_pix (
    .clk(clk), .rst_n(rst_n), .push(sf_push), .pop(sf_pop),
    .din(in_data), .dout(sf_dout),
    .empty(sf_empty), .full(sf_full), .single(sf_single)
  );

  assign lf_din = sf_pop ? sf_dout : in_data;

  upx_fifo #(.DATA_W(DATA_W), .DEPTH(ROW_DEPTH)) u_row (
    .clk(clk), .rst_n(rst_n), .push(lf_push), .pop(lf_pop),
    .din(lf_din), .dout(lf_dout),
    .empty(lf_empty), .full(lf_full), .single(lf_single)
  );

  assign emit = lf_push || lf_pop;

  always_comb begin
    unique case (phase)
      PH_COLREP: out_src = sf_dout;
      PH_ROWREP: out_src = lf_dout;
      default:   out_src = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_data <= out_src;
    end
  end
endmodule

// File: rtl/upx_checks.sv
module upx_checks (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic last_ch,
  input logic sf_push,
  input logic sf_pop,
  input logic sf_empty,
  input logic sf_full,
  input logic lf_push,
  input logic lf_pop,
  input logic lf_empty,
  input logic lf_full
);
  logic take;
  assign take = in_valid && in_ready;

  // R1
  a_r1_reset_out: assert property (@(posedge clk) !rst_n |=> !out_valid);
  a_r1_reset_rdy: assert property (@(posedge clk) !rst_n |=> in_ready);
  // R2
  a_r2_pass_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  // R3
  a_r3_colrep_start: assert property (@(posedge clk) disable iff (!rst_n)
    take && last_ch |=> sf_pop && !in_ready);
  // R5
  a_r5_rowrep_emits: assert property (@(posedge clk) disable iff (!rst_n)
    lf_pop |=> out_valid);
  // R8
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !sf_pop && !lf_pop |=> !out_valid);
  // R9
  a_r9_pix_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sf_push |-> !sf_full);
  a_r9_pix_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    sf_pop |-> !sf_empty);
  a_r9_row_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lf_push |-> !lf_full);
  a_r9_row_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    lf_pop |-> !lf_empty);
endmodule

bind upx2_top upx_checks u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .last_ch(last_ch),
  .sf_push(sf_push), .sf_pop(sf_pop), .sf_empty(sf_empty), .sf_full(sf_full),
  .lf_push(lf_push), .lf_pop(lf_pop), .lf_empty(lf_empty), .lf_full(lf_full)
);

// File: tb/sim_upx2_top.sv
`timescale 1ns/1ps
module sim_upx2_top;
  localparam int DW = 8;
  localparam int C  = 3;
  localparam int W  = 4;
  localparam int H  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  upx2_top #(.DATA_W(DW), .CHANNELS(C), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid)
  );

  int checks = 0;
  int fails = 0;
  int seen = 0;
  logic [DW-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pix(input int f, input int r, input int x, input int c);
    return DW'((f * 101 + r * 37 + x * 11 + c * 3 + 1) % 256);
  endfunction

  // monitor: scoreboard of the output stream
  always @(negedge clk) begin
    logic [DW-1:0] e;
    if (rst_n && out_valid) begin
      seen++;
      if (expq.size() == 0) chk(1'b0, "R6 unexpected output", int'(out_data), -1);
      else begin
        e = expq.pop_front();
        chk(out_data == e, "R3 R5 R6 output order", int'(out_data), int'(e));
      end
    end
  end

  // driver: present one sample, hold it through stalls, return stall length
  task automatic send(input logic [DW-1:0] d, output int n);
    in_valid = 1'b1;
    in_data = d;
    n = 0;
    while (!in_ready) begin
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    chk(out_valid && out_data == d, "R2 pass latency", int'(out_data), int'(d));
    in_valid = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit first;
    first = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
        int'({in_ready, out_valid}), 2);

    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < H; r++) begin
        for (int k = 0; k < 2; k++)
          for (int ox = 0; ox < 2 * W; ox++)
            for (int c = 0; c < C; c++)
              expq.push_back(pix(f, r, ox / 2, c));
        for (int x = 0; x < W; x++) begin
          for (int c = 0; c < C; c++) begin
            if (f == 0 && c != 0 && ((x + c + r) % 2 == 0)) begin
              @(negedge clk);
              chk(out_valid == 1'b0, "R8 idle input cycle", int'(out_valid), 0);
            end
            send(pix(f, r, x, c), n);
            if (c != 0 || first)
              chk(n == 0, "R7 no stall mid-pixel", n, 0);
            else if (x != 0)
              chk(n == C + 1, "R4 pixel stall length", n, C + 1);
            else
              chk(n == C + 1 + 2 * W * C, "R5 row stall length", n, C + 1 + 2 * W * C);
            first = 1'b0;
          end
        end
      end
    end

    n = 0;
    while (!in_ready) begin
      n++;
      @(negedge clk);
    end
    chk(n == C + 1 + 2 * W * C, "R5 final row stall length", n, C + 1 + 2 * W * C);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R6 all expected emitted", expq.size(), 0);
    chk(seen == 2 * H * 4 * W * C, "R6 output count", seen, 2 * H * 4 * W * C);
    chk(out_valid == 1'b0, "R8 quiet after frame", int'(out_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule